// File: doc/BRIEF.md
# Transposed Three-Tap FIR Filter

The block is a three-tap finite impulse response filter built in transposed, data-broadcast form. Every accepted sample is multiplied by all three coefficients in the same cycle. The products then enter a short chain of partial-sum registers that moves toward the output. The delays sit inside the adder chain and not on the input. As a result, the longest register-to-register path is one multiply followed by one add, while the direct form needs two adds after the multiply.

A build-time option splits each multiplier into two register-separated halves. The first half forms two partial products, one from the low coefficient bits and one from the high coefficient bits. The second half shifts and merges them. This shortens the cycle limit to the largest of the two multiply halves and the add, and costs one extra cycle of latency. All sums are carried at full precision: sample width plus coefficient width plus two guard bits. Only the final result is truncated. The valid strobe is delayed to match the latency. The history advances only on accepted samples. The block contains no state machine. Its only control is a sample-valid pipeline of one or two stages.

Top module: `transposed_fir`

## Requirements
- R1: For each accepted sample, the filter forms the full-precision sum h0·x[n] + h1·x[n-1] + h2·x[n-2] in ACCW = XW+CW+2 bits. x[n-1] and x[n-2] are the two previously accepted samples. `y_out` is bits [OUT_SHIFT +: ACCW-OUT_SHIFT] of that sum, which is the floor of sum / 2^OUT_SHIFT. For example, a sum of -2 with OUT_SHIFT=4 gives -1.
- R2: Cycles with `in_valid` low do not shift the sample history. The next accepted sample combines with the last two accepted samples, however many idle cycles came between them.
- R3: With FINE_GRAIN=0, the result for a sample accepted at clock edge k appears on `y_out` with `y_valid` high right after edge k+1. The latency is one cycle.
- R4: With FINE_GRAIN=1, the same result appears right after edge k+2. The latency is two cycles.
- R5: `y_valid` is high for exactly one cycle per accepted sample, at the latency of R3 or R4. It is low in every other cycle.
- R6: Synchronous reset (`rst` high at a clock edge) clears `y_out` to 0, `y_valid` to 0 and all partial-sum and multiplier registers. The first results after reset therefore equal those of an all-zero history: h0·x0 first, then h0·x1 + h1·x0.
- R7: FINE_GRAIN=1 produces the same value sequence as FINE_GRAIN=0 for the same input stream. It also handles back-to-back accepted samples.
- R8: No intermediate sum wraps. Three products of the most negative sample and the most negative coefficient (-2048 · -512 with the default widths) sum to 3·2^20, and the output gives 196608.
- R9: Between results, `y_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on `x_in` is accepted this cycle |
| x_in | input | XW | Signed input sample |
| h0 | input | CW | Signed coefficient applied to the newest sample |
| h1 | input | CW | Signed coefficient applied to the previous sample |
| h2 | input | CW | Signed coefficient applied to the sample two back |
| y_valid | output | 1 | `y_out` carries a new result this cycle |
| y_out | output | XW+CW+2-OUT_SHIFT | Signed truncated filter result |

## Verification
The filter is driven with mixed-sign coefficients and back-to-back samples, including a negative full-scale sample. This separates correct tap ordering from a reversed or misrouted chain. Idle gaps placed between accepted samples show whether the history wrongly advances on idle cycles and whether the output holds. A single isolated pulse separates the one-cycle and two-cycle latencies. A sum of -2 exposes rounding where flooring is required. A triple full-scale negative product exposes any guard-bit shortfall. One plain instance and one split instance run on the same stream, so any value difference introduced by the split multiplier shows up. A reset in the middle of the stream shows whether the stale history is really cleared.

// File: rtl/fir_pkg.sv
package fir_pkg;
    // Number of coefficient taps in the transposed chain.
    localparam int NTAPS = 3;
    // Extra accumulator bits above the raw product width.
    localparam int GUARD_BITS = 2;
endpackage

// File: rtl/fir_tap_mult.sv
module fir_tap_mult #(
    parameter int XW    = 12,
    parameter int CW    = 10,
    parameter int PW    = 24,
    parameter bit SPLIT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [XW-1:0] x,
    input  logic signed [CW-1:0] c,
    output logic        [PW-1:0] prod
);
    localparam int FW = XW + CW;
    localparam int LO = CW / 2;
    localparam int HI = CW - LO;
    localparam int LW = XW + LO + 1;
    localparam int HW = XW + HI;

    // Direct full product, used for the plain path and as a reference.
    logic signed [FW-1:0] x_full, c_full, full_prod;
    logic signed [PW-1:0] full_ref;

    always_comb begin
        x_full    = {{(FW-XW){x[XW-1]}}, x};
        c_full    = {{(FW-CW){c[CW-1]}}, c};
        full_prod = x_full * c_full;
        full_ref  = {{(PW-FW){full_prod[FW-1]}}, full_prod};
    end

    generate
        if (SPLIT) begin : g_split
            logic signed [LW-1:0] x_lo, c_lo, lo_c, lo_q;
            logic signed [HW-1:0] x_hi, c_hi, hi_c, hi_q;
            logic signed [PW-1:0] lo_ext, hi_ext;

            always_comb begin
                x_lo = {{(LW-XW){x[XW-1]}}, x};
                c_lo = {{(LW-LO){1'b0}}, c[LO-1:0]};
                lo_c = x_lo * c_lo;
                x_hi = {{(HW-XW){x[XW-1]}}, x};
                c_hi = {{(HW-HI){c[CW-1]}}, c[CW-1:LO]};
                hi_c = x_hi * c_hi;
            end

            // First half: two partial products held in registers.
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (en) begin
                    lo_q <= lo_c;
                    hi_q <= hi_c;
                end
            end

            // Second half: shift and merge.
            always_comb begin
                lo_ext = {{(PW-LW){lo_q[LW-1]}}, lo_q};
                hi_ext = {{(PW-HW){hi_q[HW-1]}}, hi_q};
                prod   = (hi_ext <<< LO) + lo_ext;
            end

            // R7
            split_product_chk: assert property (@(posedge clk) disable iff (rst)
                en |=> (prod == $past(full_ref)));
        end else begin : g_plain
            assign prod = full_ref;

            // R1
            zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
                (en && (x == '0 || c == '0)) |-> (prod == '0));
        end
    endgenerate
endmodule

// File: rtl/fir_sum_chain.sv
module fir_sum_chain
    import fir_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [NTAPS-1:0][PW-1:0]    prods,
    output logic [PW-1:0]               acc
);
    // st[0] is the output sum, st[NTAPS-1] holds the oldest tap product.
    logic [NTAPS-1:0][PW-1:0] st;
    logic [NTAPS-1:0][PW-1:0] upstream;
    logic [NTAPS-1:0][PW-1:0] nxt;

    assign upstream = {{PW{1'b0}}, st[NTAPS-1:1]};

    always_comb begin
        for (int k = 0; k < NTAPS; k++) begin
            nxt[k] = prods[k] + upstream[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (en) begin
            st <= nxt;
        end
    end

    assign acc = st[0];

    // R2
    history_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st));

    // R9
    output_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

    // R6
    chain_clear_chk: assert property (@(posedge clk)
        rst |=> (st == '0));
endmodule

// File: rtl/transposed_fir.sv
module transposed_fir
    import fir_pkg::*;
#(
    parameter int XW         = 12,
    parameter int CW         = 10,
    parameter int OUT_SHIFT  = 4,
    parameter bit FINE_GRAIN = 1'b0,
    localparam int ACCW      = XW + CW + GUARD_BITS,
    localparam int YW        = ACCW - OUT_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [CW-1:0] h0,
    input  logic signed [CW-1:0] h1,
    input  logic signed [CW-1:0] h2,
    output logic                 y_valid,
    output logic signed [YW-1:0] y_out
);
    logic [NTAPS-1:0][CW-1:0]   coefs;
    logic [NTAPS-1:0][ACCW-1:0] prods;
    logic [ACCW-1:0]            acc;
    logic                       chain_en;
    logic                       trunc_unused;

    assign coefs = {h2, h1, h0};

    // Broadcast: the same sample reaches every tap multiplier.
    generate
        for (genvar t = 0; t < NTAPS; t++) begin : g_tap
            fir_tap_mult #(
                .XW(XW), .CW(CW), .PW(ACCW), .SPLIT(FINE_GRAIN)
            ) u_mul (
                .clk(clk), .rst(rst), .en(in_valid),
                .x(x_in), .c(coefs[t]), .prod(prods[t])
            );
        end

        if (FINE_GRAIN) begin : g_fg_valid
            logic stage_valid;
            always_ff @(posedge clk) begin
                if (rst) stage_valid <= 1'b0;
                else     stage_valid <= in_valid;
            end
            assign chain_en = stage_valid;

            // R4
            fg_first_stage_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> stage_valid);
            // R4
            fg_latency_chk: assert property (@(posedge clk) disable iff (rst)
                stage_valid |=> y_valid);
            // R5
            fg_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !stage_valid |=> !y_valid);
        end else begin : g_plain_valid
            assign chain_en = in_valid;

            // R3
            plain_latency_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> y_valid);
            // R5
            plain_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !y_valid);
        end
    endgenerate

    fir_sum_chain #(.PW(ACCW)) u_chain (
        .clk(clk), .rst(rst), .en(chain_en), .prods(prods), .acc(acc)
    );

    always_ff @(posedge clk) begin
        if (rst) y_valid <= 1'b0;
        else     y_valid <= chain_en;
    end

    // Truncation only at the final output.
    assign y_out        = acc[OUT_SHIFT +: YW];
    assign trunc_unused = ^acc[OUT_SHIFT-1:0];

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!y_valid && y_out == '0));
endmodule

// File: tb/tb_transposed_fir.sv
module tb_transposed_fir;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 12;
    localparam int CW = 10;
    localparam int SH = 4;
    localparam int YW = XW + CW + 2 - SH;
    localparam int NV = 6;
    // {valid, sample, expected y} with h0=3, h1=-5, h2=7 after reset
    localparam int TV [NV][3] = '{
        '{1,    16,    3},
        '{1,    32,    1},
        '{1,   -48,  -12},
        '{0,     0,  -12},
        '{1,    80,   44},
        '{1, -2048, -430}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vin = 1'b0;
    logic signed [XW-1:0] xin = '0;
    logic signed [CW-1:0] hc0 = '0, hc1 = '0, hc2 = '0;
    logic v0, v1;
    logic signed [YW-1:0] y0, y1;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // Reference model state (direct form)
    int mx1 = 0, mx2 = 0, e1 = 0, e2 = 0;
    bit ev1 = 1'b0, ev2 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    transposed_fir #(.XW(XW), .CW(CW), .OUT_SHIFT(SH), .FINE_GRAIN(1'b0)) dut (
        .clk(clk), .rst(rst), .in_valid(vin), .x_in(xin),
        .h0(hc0), .h1(hc1), .h2(hc2), .y_valid(v0), .y_out(y0)
    );

    transposed_fir #(.XW(XW), .CW(CW), .OUT_SHIFT(SH), .FINE_GRAIN(1'b1)) dut_fg (
        .clk(clk), .rst(rst), .in_valid(vin), .x_in(xin),
        .h0(hc0), .h1(hc1), .h2(hc2), .y_valid(v1), .y_out(y1)
    );

    always @(posedge clk) begin
        if (rst) begin
            mx1 <= 0; mx2 <= 0; e1 <= 0; e2 <= 0; ev1 <= 1'b0; ev2 <= 1'b0;
        end else begin
            if (vin) begin
                e1  <= (int'(hc0) * int'(xin) + int'(hc1) * mx1 + int'(hc2) * mx2) >>> SH;
                mx1 <= int'(xin);
                mx2 <= mx1;
            end
            ev1 <= vin;
            ev2 <= ev1;
            if (ev1) e2 <= e1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Continuous comparison of both instances against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R1 R3 plain value", int'(y0), e1);
            chk("R5 plain valid", int'(v0), int'(ev1));
            chk("R7 R4 split value", int'(y1), e2);
            chk("R5 R4 split valid", int'(v1), int'(ev2));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input int x);
        vin = v;
        xin = XW'(x);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        vin = 1'b0;
        tick();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        hc0 = 10'sd3; hc1 = -10'sd5; hc2 = 10'sd7;
        do_reset();
        // R6: reset state
        chk("R6 reset y", int'(y0), 0);
        chk("R6 reset valid", int'(v0), 0);
        chk("R6 reset split y", int'(y1), 0);
        chk("R6 reset split valid", int'(v1), 0);
        chk_on = 1'b1;

        // R1, R6: table walk from an all-zero history
        for (int i = 0; i < NV; i++) begin
            drive(TV[i][0] != 0, TV[i][1]);
            tick();
            chk("R1 table value", int'(y0), TV[i][2]);
            chk("R5 table valid", int'(v0), TV[i][0]);
        end
        drive(1'b0, 0);
        tick();
        tick();

        // R3, R4: isolated pulse latency, R1 floor truncation
        hc0 = 10'sd2; hc1 = '0; hc2 = '0;
        do_reset();
        drive(1'b1, 100);
        tick();
        chk("R3 plain valid at +1", int'(v0), 1);
        chk("R3 plain value at +1", int'(y0), 12);
        chk("R4 split not yet valid", int'(v1), 0);
        drive(1'b1, -1);
        tick();
        chk("R4 split valid at +2", int'(v1), 1);
        chk("R4 split value at +2", int'(y1), 12);
        chk("R1 floor of -2", int'(y0), -1);
        drive(1'b0, 0);
        tick();
        chk("R1 split floor of -2", int'(y1), -1);
        chk("R5 plain valid drops", int'(v0), 0);
        tick();

        // R8: full-scale negative products, no wrap
        hc0 = -10'sd512; hc1 = -10'sd512; hc2 = -10'sd512;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, -2048);
            tick();
        end
        chk("R8 full scale plain", int'(y0), 196608);
        drive(1'b0, 0);
        tick();
        chk("R8 full scale split", int'(y1), 196608);

        // R2, R9: idle gaps do not shift history, output holds
        hc0 = 10'sd1; hc1 = 10'sd2; hc2 = 10'sd4;
        do_reset();
        drive(1'b1, 16);
        tick();
        chk("R6 first output after reset", int'(y0), 1);
        drive(1'b0, 999);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 hold during idle", int'(y0), 1);
        end
        drive(1'b1, 32);
        tick();
        chk("R2 history skips idles", int'(y0), 4);
        drive(1'b0, -7);
        tick();
        tick();
        chk("R9 hold after result", int'(y0), 4);
        drive(1'b1, 0);
        tick();
        chk("R2 two-back sample", int'(y0), 8);

        // R6: reset mid-stream clears history
        do_reset();
        chk("R6 mid reset y", int'(y0), 0);
        drive(1'b1, 16);
        tick();
        chk("R6 history cleared", int'(y0), 1);
        drive(1'b0, 0);
        tick();
        chk("R6 split history cleared", int'(y1), 1);
        tick();

        finish_run();
    end
endmodule